// File: doc/BRIEF.md
# Arithmetic Condition Flag Unit

This block is the flag side of an 8-bit accumulator datapath. It combines two operands under a three-bit operation code, presents the result combinationally, and keeps a registered status word with five condition flags: carry, nibble (digit) carry, zero, signed overflow and negative. The operation code also fixes which flags an instruction may change. Arithmetic changes all five. Logical operations and the move-with-test change only zero and negative. Plain moves change none.

The status register updates on a clock edge only when the instruction strobe is high. Software can also load the flags directly through a write port, and that write wins over an instruction retiring in the same cycle. A branch-test port picks one flag and a polarity and reports, from the registered flags, whether a conditional branch would be taken.

Top module: `alu_flag_status`

## Requirements
- R1: The status word is 8 bits: carry at bit 0, digit carry at bit 1, zero at bit 2, overflow at bit 3, negative at bit 4. Bits 7:5 always read 0. Reset (rst_n low) clears the word to 0x00.
- R2: `result` follows the inputs combinationally. Op 0 = opa+opb, 1 = opa-opb, 2 = AND, 3 = OR, 4 = XOR, 5 = opa (move), 6 = opa (move-with-test), 7 = opb (move). All are truncated to 8 bits.
- R3: Carry is the carry out of bit 7. For op 0 that is the carry of opa+opb. For op 1 it is the carry of opa+~opb+1, so carry = 1 means opa >= opb unsigned (no borrow).
- R4: Digit carry is the carry from bit 3 into bit 4, using the same sum as R3. For op 1 it is 1 when opa[3:0] >= opb[3:0].
- R5: Zero is 1 exactly when the 8-bit result is 0. Negative equals result bit 7.
- R6: Overflow is 1 when the signed (two's complement) sum or difference lies outside -128..127.
- R7: Ops 0 and 1 update all five flags. Ops 2, 3, 4 and 6 update only zero and negative and keep the other three. Ops 5 and 7 keep every flag.
- R8: The flags change only on a rising clock edge with `valid` high. With `valid` and `wr_en` both low, the status word holds.
- R9: With `wr_en` high, the next edge loads status bits 4:0 from `wr_data[4:0]`, whatever `valid` and `op` are. `wr_data[7:5]` is ignored.
- R10: `take` is computed from the registered status. For `br_sel` 0..4 it is 1 when status bit `br_sel` equals `br_set`. For `br_sel` 5..7 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| op | input | 3 | Operation code (R2) |
| valid | input | 1 | Instruction retires this cycle; enables the flag update |
| wr_en | input | 1 | Direct load of the flags |
| wr_data | input | 8 | Value for the direct load; bits 7:5 unused |
| br_sel | input | 3 | Flag index for the branch test |
| br_set | input | 1 | 1: take the branch if the flag is set; 0: take it if the flag is clear |
| result | output | 8 | Operation result |
| status | output | 8 | Registered status word |
| take | output | 1 | Branch condition met |

## Verification
A direct flag write and a retiring arithmetic instruction can land on the same edge. The bench provokes this by raising `wr_en` and `valid` together with an operation whose flags differ from the written pattern. It judges the status seen after that edge against the written value, not the computed one. The second collision is a branch test against flags that change on that same edge. `take` is sampled just after the edge and must match the newly stored flags.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4,
      OP_MOVA = 3'd5,
      OP_MOVT = 3'd6,
      OP_MOVB = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_ZN   = 2'd1,
      CLS_ALL  = 2'd2
   } upd_cls_e;

   localparam int NUM_FLAGS = 5;
   localparam int FLG_C     = 0;
   localparam int FLG_DC    = 1;
   localparam int FLG_Z     = 2;
   localparam int FLG_OV    = 3;
   localparam int FLG_N     = 4;

   // packed: first member is the MSB, so c lands at bit 0
   typedef struct packed {
      logic n;
      logic ov;
      logic z;
      logic dc;
      logic c;
   } flags_t;

endpackage

// File: rtl/alu_flag_datapath.sv
module alu_flag_datapath
   import alu_flag_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  op_e               op,
   output logic [DATA_W-1:0] res,
   output flags_t            raw
);

   localparam int MSB   = DATA_W - 1;
   localparam int MID_W = DATA_W - 1 - NIB_W;

   generate
      if (NIB_W < 1 || MID_W < 1) begin : g_bad_split
         $error("alu_flag_datapath: NIB_W must leave at least one middle bit");
      end
   endgenerate

   logic              is_sub;
   logic [DATA_W-1:0] bx;
   logic [NIB_W:0]    lo_sum;
   logic [MID_W:0]    mid_sum;
   logic [1:0]        top_sum;
   logic [DATA_W-1:0] arith;

   // segmented adder: nibble, middle, sign bit, so both inner carries are visible
   always_comb begin
      is_sub  = (op == OP_SUB);
      bx      = is_sub ? ~b : b;
      lo_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, bx[NIB_W-1:0]}
              + {{NIB_W{1'b0}}, is_sub};
      mid_sum = {1'b0, a[MSB-1:NIB_W]} + {1'b0, bx[MSB-1:NIB_W]}
              + {{MID_W{1'b0}}, lo_sum[NIB_W]};
      top_sum = {1'b0, a[MSB]} + {1'b0, bx[MSB]} + {1'b0, mid_sum[MID_W]};
      arith   = {top_sum[0], mid_sum[MID_W-1:0], lo_sum[NIB_W-1:0]};
   end

   always_comb begin
      unique case (op)
         OP_ADD,
         OP_SUB:  res = arith;
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_MOVA,
         OP_MOVT: res = a;
         OP_MOVB: res = b;
         default: res = a;
      endcase
   end

   always_comb begin
      raw.c  = top_sum[1];
      raw.dc = lo_sum[NIB_W];
      raw.ov = top_sum[1] ^ mid_sum[MID_W];
      raw.z  = ~|res;
      raw.n  = res[MSB];
   end

   // cross-check of the segmented chain against a single wide addition
   always_comb begin
      if (op == OP_ADD) begin
         assert_carry_sum_R3: assert ({raw.c, res} == ({1'b0, a} + {1'b0, b}))
            else $error("segmented add disagrees with wide add");
      end
   end

endmodule

// File: rtl/alu_flag_class.sv
module alu_flag_class
   import alu_flag_pkg::*;
(
   input  op_e    op,
   output flags_t mask
);

   upd_cls_e cls;

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB:                 cls = CLS_ALL;
         OP_AND, OP_OR, OP_XOR, OP_MOVT: cls = CLS_ZN;
         default:                        cls = CLS_NONE;
      endcase
   end

   always_comb begin
      mask = '0;
      unique case (cls)
         CLS_ALL: mask = '1;
         CLS_ZN:  begin
            mask.z = 1'b1;
            mask.n = 1'b1;
         end
         default: mask = '0;
      endcase
   end

   always_comb begin
      assert_class_shape_R7: assert ($countones(mask) == 0 || $countones(mask) == 2
                                     || $countones(mask) == NUM_FLAGS)
         else $error("update mask has an unexpected shape");
   end

endmodule

// File: rtl/alu_flag_branch.sv
module alu_flag_branch
   import alu_flag_pkg::*;
#(
   parameter int STAT_W = 8,
   parameter int SEL_W  = 3
) (
   input  logic [STAT_W-1:0] status,
   input  logic [SEL_W-1:0]  sel,
   input  logic              want_set,
   output logic              take
);

   generate
      if ((1 << SEL_W) < STAT_W) begin : g_bad_sel
         $error("alu_flag_branch: SEL_W too narrow for STAT_W");
      end
   endgenerate

   logic [(1<<SEL_W)-1:0] flag_vec;

   generate
      for (genvar i = 0; i < (1 << SEL_W); i++) begin : g_vec
         if (i < NUM_FLAGS) begin : g_flag
            assign flag_vec[i] = status[i];
         end else begin : g_none
            assign flag_vec[i] = 1'b0;
         end
      end
   endgenerate

   logic in_range;

   always_comb begin
      in_range = (int'(sel) < NUM_FLAGS);
      take     = in_range && (flag_vec[sel] == want_set);
   end

   always_comb begin
      if (!in_range) begin
         assert_no_take_unused_R10: assert (!take)
            else $error("branch taken on an unused status bit");
      end
   end

endmodule

// File: rtl/alu_flag_status.sv
module alu_flag_status
   import alu_flag_pkg::*;
#(
   parameter  int DATA_W = 8,
   parameter  int NIB_W  = 4,
   parameter  int STAT_W = 8,
   localparam int SEL_W  = $clog2(STAT_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [2:0]        op,
   input  logic              valid,
   input  logic              wr_en,
   input  logic [STAT_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  br_sel,
   input  logic              br_set,
   output logic [DATA_W-1:0] result,
   output logic [STAT_W-1:0] status,
   output logic              take
);

   generate
      if (STAT_W < NUM_FLAGS + 1) begin : g_bad_stat
         $error("alu_flag_status: STAT_W must exceed the flag count");
      end
   endgenerate

   op_e    op_q;
   flags_t raw;
   flags_t mask;
   flags_t flg_q;
   flags_t flg_d;

   assign op_q = op_e'(op);

   alu_flag_datapath #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_dp (
      .a   (opa),
      .b   (opb),
      .op  (op_q),
      .res (result),
      .raw (raw)
   );

   alu_flag_class u_cls (
      .op   (op_q),
      .mask (mask)
   );

   always_comb begin
      flg_d = flg_q;
      if (wr_en) begin
         flg_d = flags_t'(wr_data[NUM_FLAGS-1:0]);
      end else if (valid) begin
         flg_d = (raw & mask) | (flg_q & ~mask);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flg_q <= '0;
      end else begin
         flg_q <= flg_d;
      end
   end

   logic unused_wr_hi;
   assign unused_wr_hi = ^wr_data[STAT_W-1:NUM_FLAGS];

   generate
      for (genvar i = 0; i < STAT_W; i++) begin : g_stat
         if (i < NUM_FLAGS) begin : g_live
            assign status[i] = flg_q[i];
         end else begin : g_pad
            assign status[i] = 1'b0;
         end
      end
   endgenerate

   alu_flag_branch #(.STAT_W(STAT_W), .SEL_W(SEL_W)) u_br (
      .status   (status),
      .sel      (br_sel),
      .want_set (br_set),
      .take     (take)
   );

   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && !wr_en) |=> $stable(status));

   assert_move_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !wr_en && (op_q == OP_MOVA || op_q == OP_MOVB)) |=> $stable(status));

   assert_test_keeps_cov_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !wr_en && op_q == OP_MOVT)
      |=> ($stable(status[FLG_C]) && $stable(status[FLG_DC]) && $stable(status[FLG_OV])));

   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (status[NUM_FLAGS-1:0] == $past(wr_data[NUM_FLAGS-1:0])));

   assert_sign_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !wr_en && op_q == OP_XOR) |=> (status[FLG_N] == $past(opa[DATA_W-1] ^ opb[DATA_W-1])));

endmodule

// File: tb/test_alu_flag_status.sv
`timescale 1ns/1ps
module test_alu_flag_status;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] opa = '0, opb = '0, wr_data = '0;
   logic [2:0] op = '0, br_sel = '0;
   logic       valid = 1'b0, wr_en = 1'b0, br_set = 1'b0;
   logic [7:0] result, status;
   logic       take;

   always #2.5 clk = ~clk;

   alu_flag_status i_alu_flag_status (
      .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op(op),
      .valid(valid), .wr_en(wr_en), .wr_data(wr_data),
      .br_sel(br_sel), .br_set(br_set),
      .result(result), .status(status), .take(take)
   );

   typedef struct {
      logic [7:0] res;
      logic [7:0] st;
      logic       tk;
      string      req;
   } item_t;

   item_t      sb_q[$];
   int         n_vec = 0;
   int         n_bad = 0;
   logic [4:0] m_st = '0;   // model flags {n,ov,z,dc,c}
   bit         done = 0;

   task automatic compare(input item_t e, input logic [7:0] r, input logic [7:0] s, input logic t);
      n_vec++;
      if (r !== e.res || s !== e.st || t !== e.tk) begin
         n_bad++;
         $display("FAIL %s: result=%h status=%h take=%b expected result=%h status=%h take=%b",
                  e.req, r, s, t, e.res, e.st, e.tk);
      end
   endtask

   // independent reference for R2..R7
   task automatic model(input logic [7:0] a, input logic [7:0] b, input logic [2:0] o,
                        output logic [7:0] r, output logic [4:0] f, output logic [4:0] msk);
      int sa, sb_, sr;
      logic c, dc, ov;
      sa = $signed(a); sb_ = $signed(b);
      c = 0; dc = 0; ov = 0;
      case (o)
         3'd0: begin
            r  = a + b;
            c  = (int'(a) + int'(b)) > 255;
            dc = (int'(a[3:0]) + int'(b[3:0])) > 15;
            sr = sa + sb_;
            ov = (sr < -128) || (sr > 127);
            msk = 5'b11111;
         end
         3'd1: begin
            r  = a - b;
            c  = (a >= b);
            dc = (a[3:0] >= b[3:0]);
            sr = sa - sb_;
            ov = (sr < -128) || (sr > 127);
            msk = 5'b11111;
         end
         3'd2: begin r = a & b; msk = 5'b10100; end
         3'd3: begin r = a | b; msk = 5'b10100; end
         3'd4: begin r = a ^ b; msk = 5'b10100; end
         3'd5: begin r = a;     msk = 5'b00000; end
         3'd6: begin r = a;     msk = 5'b10100; end
         default: begin r = b;  msk = 5'b00000; end
      endcase
      f = {r[7], ov, (r == 8'h00), dc, c};
   endtask

   task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [2:0] o,
                        input logic v, input logic w, input logic [7:0] wd,
                        input logic [2:0] sel, input logic set, input string req);
      item_t e;
      logic [7:0] r;
      logic [4:0] f, msk;
      @(negedge clk);
      opa = a; opb = b; op = o; valid = v; wr_en = w; wr_data = wd;
      br_sel = sel; br_set = set;
      model(a, b, o, r, f, msk);
      if (w)      m_st = wd[4:0];
      else if (v) m_st = (f & msk) | (m_st & ~msk);
      e.res = r;
      e.st  = {3'b000, m_st};
      e.tk  = (sel < 3'd5) ? (m_st[sel] == set) : 1'b0;
      e.req = req;
      sb_q.push_back(e);
   endtask

   // monitor: one expected item per edge, sampled 1 ns after it
   initial begin
      item_t e;
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            compare(e, result, status, take);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: result=%h status=%h take=%b expected run to complete",
                  result, status, take);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      item_t e;
      // R1: reset state, take with sel=C polarity clear -> 1
      #7;
      e.res = 8'h00; e.st = 8'h00; e.tk = 1'b1; e.req = "R1 reset";
      compare(e, result, status, take);
      @(negedge clk);
      rst_n = 1'b1;

      // R3 R4 R5 R6: adds
      apply(8'h0F, 8'h01, 3'd0, 1, 0, 0, 3'd1, 1, "R4 nibble carry add");
      apply(8'hFF, 8'h01, 3'd0, 1, 0, 0, 3'd0, 1, "R3 carry out add");
      apply(8'h7F, 8'h01, 3'd0, 1, 0, 0, 3'd3, 1, "R6 positive overflow");
      apply(8'h80, 8'h80, 3'd0, 1, 0, 0, 3'd2, 1, "R5 zero after wrap");
      // R3 R4 R6: subtracts
      apply(8'h05, 8'h05, 3'd1, 1, 0, 0, 3'd0, 1, "R3 equal subtract no borrow");
      apply(8'h00, 8'h01, 3'd1, 1, 0, 0, 3'd4, 1, "R3 borrow and negative");
      apply(8'h80, 8'h01, 3'd1, 1, 0, 0, 3'd3, 1, "R6 negative overflow");
      apply(8'h10, 8'h01, 3'd1, 1, 0, 0, 3'd1, 0, "R4 nibble borrow");
      // R7: logic keeps C/DC/OV, MOVs keep all, MOVT only Z/N
      apply(8'hFF, 8'h01, 3'd0, 1, 0, 0, 3'd0, 1, "R7 setup carry");
      apply(8'hF0, 8'h0F, 3'd2, 1, 0, 0, 3'd0, 1, "R7 and keeps carry");
      apply(8'hF0, 8'h0F, 3'd3, 1, 0, 0, 3'd4, 1, "R2 or result");
      apply(8'hAA, 8'hAA, 3'd4, 1, 0, 0, 3'd2, 1, "R5 xor zero");
      apply(8'h00, 8'h33, 3'd5, 1, 0, 0, 3'd2, 1, "R7 move keeps flags");
      apply(8'h81, 8'h00, 3'd7, 1, 0, 0, 3'd4, 0, "R7 move b keeps flags");
      apply(8'h81, 8'h00, 3'd6, 1, 0, 0, 3'd4, 1, "R7 test move sets N");
      // R8: no strobe, no change
      apply(8'h00, 8'h00, 3'd1, 0, 0, 0, 3'd2, 0, "R8 idle hold");
      // R9: write, upper bits ignored; write beats valid
      apply(8'h01, 8'h01, 3'd0, 0, 1, 8'hFF, 3'd3, 1, "R9 write ignores high bits");
      apply(8'hFF, 8'h01, 3'd0, 1, 1, 8'h08, 3'd0, 0, "R9 write wins over add");
      apply(8'hFF, 8'h01, 3'd0, 1, 1, 8'hE0, 3'd3, 0, "R9 write clears low bits");
      // R10: every select, both polarities
      for (int s = 0; s < 8; s++) begin
         apply(8'h00, 8'h00, 3'd5, 1, 0, 0, 3'(s), 1, "R10 select set");
         apply(8'h00, 8'h00, 3'd5, 1, 0, 0, 3'(s), 0, "R10 select clear");
      end
      apply(8'h00, 8'h00, 3'd0, 1, 1, 8'h15, 3'd2, 1, "R10 take on fresh write");
      for (int s = 0; s < 8; s++) begin
         apply(8'h00, 8'h00, 3'd5, 0, 0, 0, 3'(s), 1, "R10 select after write");
      end
      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         apply(8'($urandom), 8'($urandom), 3'($urandom), 1'($urandom),
               ($urandom % 8) == 0, 8'($urandom), 3'($urandom), 1'($urandom),
               "R2 R7 mixed");
      end
      @(negedge clk);
      valid = 0; wr_en = 0;
      repeat (3) @(posedge clk);
      #2;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule